// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block models one output cell of a small programmable logic device. A set of product-term signals arrives from the AND array. The cell ORs them into one sum term, and it can route that sum straight to the pin or capture it in a flip-flop first. Two configuration bits set the cell's behaviour: one picks registered or combinatorial operation, and the other picks true or inverted pin polarity. The polarity setting applies in both modes.

The cell has one more product term of its own, and that term only enables the pin driver. Two product terms are shared by every registered cell. One clears the flip-flop at once. The other sets the flip-flop on the next clock edge. Both act on the flip-flop before the polarity stage, so the pin level after a clear follows the polarity setting. A preload path forces the flip-flop to a chosen value for test. The cell returns a feedback signal to the array.

The pin appears as three separate signals: the driven level, the driver enable and the sensed level. These are the usual split of a bidirectional pad. Every input is a plain level that the cell samples. None of them carries a stream, so the cell has no valid/ready handshake and applies no back-pressure.

Top module: `pld_out_cell`

## Requirements
- R1: In combinatorial mode (`mode_reg`=0), `pad_o` equals the OR of all `NUM_TERMS` bits of `terms` XOR `pol_inv`. It follows `terms` with no clock edge. `NUM_TERMS` may be 8, 10 or 12.
- R2: In registered mode (`mode_reg`=1), the flip-flop captures the OR of `terms` on each rising edge of `clk`, and `pad_o` shows the captured value XOR `pol_inv`.
- R3: When `pol_inv`=1, `pad_o` is the inverse of the value it would have with `pol_inv`=0. This holds in both modes.
- R4: `pad_oe` follows `oe_term`. When it is 0 the driver is off, and `pad_i` carries the external level.
- R5: While `ar_term` is 1, the flip-flop holds 0 and no clock edge is needed for this. In registered mode `pad_o` then equals `pol_inv`.
- R6: If `sp_term` is 1 at a rising edge (and neither `ar_term` nor `preload_en` is 1), the flip-flop becomes 1 after that edge.
- R7: `ar_term` takes priority over `sp_term` and over `preload_en`. The flip-flop stays 0 whenever `ar_term` is 1.
- R8: While `rst_n` is 0 the flip-flop holds 0.
- R9: If `preload_en` is 1 at a rising edge (and `ar_term` is 0), the flip-flop loads `preload_val`. The preload wins over `sp_term`.
- R10: `fb` equals `pad_i` in combinatorial mode. In registered mode it equals the inverted flip-flop state, that is NOT (`pad_o` XOR `pol_inv`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge |
| rst_n | input | 1 | Power-up reset, active low, clears the flip-flop |
| terms | input | NUM_TERMS | Logic product terms from the AND array |
| oe_term | input | 1 | Product term for the output enable |
| ar_term | input | 1 | Shared asynchronous-clear product term |
| sp_term | input | 1 | Shared synchronous-set product term |
| preload_en | input | 1 | Test preload strobe, sampled on the clock edge |
| preload_val | input | 1 | Value loaded by the preload |
| mode_reg | input | 1 | Configuration: 1 registered, 0 combinatorial |
| pol_inv | input | 1 | Configuration: 1 inverted pin polarity |
| pad_i | input | 1 | Level sensed on the pin |
| pad_o | output | 1 | Level driven on the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback to the array |

## Verification
The bench raises the clear term in the middle of a cycle, with no clock edge between it and the check. A design that waited for an edge would show the old pin level. The clear is checked under both polarity settings, so a design that cleared the pin level rather than the flip-flop gives the wrong level in one of them. The clear is also raised together with the set term and together with the preload, and the preload together with the set term. A design with the priorities out of order would leave the flip-flop at 1. With the driver off, the bench places external levels on the pin that differ from the driven level. A design that took feedback from the driven level would report the wrong feedback.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic {SRC_COMB = 1'b0, SRC_REG = 1'b1} src_e;

  function automatic logic apply_pol(input logic v, input logic inv);
    return inv ? ~v : v;
  endfunction
endpackage

// File: rtl/pld_sum_term.sv
module pld_sum_term #(
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] terms,
  output logic                 sum
);
  localparam int CHAIN_W = NUM_TERMS + 1;
  logic [CHAIN_W-1:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_TERMS; g++) begin : g_or
    assign chain[g+1] = chain[g] | terms[g];
  end
  assign sum = chain[CHAIN_W-1];
endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ar,
  input  logic sp,
  input  logic pl_en,
  input  logic pl_val,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n or posedge ar) begin
    if (!rst_n)     q <= 1'b0;
    else if (ar)    q <= 1'b0;
    else if (pl_en) q <= pl_val;
    else if (sp)    q <= 1'b1;
    else            q <= d;
  end

  // R5
  ar_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) ar |-> !q);
  // R6
  sp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp && !ar && !pl_en) |=> (q || ar));
  // R9
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_en && !ar) |=> (ar || q == $past(pl_val)));
endmodule

// File: rtl/pld_out_stage.sv
module pld_out_stage
  import pld_cell_pkg::*;
(
  input  logic mode_reg,
  input  logic pol_inv,
  input  logic sum,
  input  logic q,
  input  logic oe_term,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe,
  output logic fb
);
  src_e src;
  logic level;

  always_comb begin
    src   = mode_reg ? SRC_REG : SRC_COMB;
    level = (src == SRC_REG) ? q : sum;
    pad_o = apply_pol(level, pol_inv);
    fb    = (src == SRC_REG) ? ~q : pad_i;
  end
  assign pad_oe = oe_term;
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell #(
  parameter int NUM_TERMS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TERMS-1:0] terms,
  input  logic                 oe_term,
  input  logic                 ar_term,
  input  logic                 sp_term,
  input  logic                 preload_en,
  input  logic                 preload_val,
  input  logic                 mode_reg,
  input  logic                 pol_inv,
  input  logic                 pad_i,
  output logic                 pad_o,
  output logic                 pad_oe,
  output logic                 fb
);
  logic sum;
  logic q;

  pld_sum_term #(.NUM_TERMS(NUM_TERMS)) u_sum (.terms(terms), .sum(sum));

  pld_cell_reg u_reg (
    .clk(clk), .rst_n(rst_n), .ar(ar_term), .sp(sp_term),
    .pl_en(preload_en), .pl_val(preload_val), .d(sum), .q(q)
  );

  pld_out_stage u_out (
    .mode_reg(mode_reg), .pol_inv(pol_inv), .sum(sum), .q(q),
    .oe_term(oe_term), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .fb(fb)
  );

  // R2
  reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_reg && !ar_term && !sp_term && !preload_en) |=>
      (ar_term || !mode_reg || (pad_o ^ pol_inv) == $past(|terms)));
  // R10
  fb_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reg |-> (fb == ~(pad_o ^ pol_inv)));
endmodule

// File: tb/pld_out_cell_test.sv
module pld_out_cell_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] terms = '0;
  logic oe_term = 1'b1, ar_term = 1'b0, sp_term = 1'b0;
  logic preload_en = 1'b0, preload_val = 1'b0;
  logic mode_reg = 1'b1, pol_inv = 1'b1;
  logic ext_lvl = 1'b0;
  logic pad_i, pad_o, pad_oe, fb;

  int total = 0, bad = 0;
  logic qm = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign pad_i = pad_oe ? pad_o : ext_lvl;

  pld_out_cell #(.NUM_TERMS(NT)) uut (
    .clk(clk), .rst_n(rst_n), .terms(terms), .oe_term(oe_term), .ar_term(ar_term),
    .sp_term(sp_term), .preload_en(preload_en), .preload_val(preload_val),
    .mode_reg(mode_reg), .pol_inv(pol_inv), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .fb(fb)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run(input string req);
    logic qe, src, epo, epi, efb;
    @(negedge clk);
    qe  = (ar_term || !rst_n) ? 1'b0 : qm;
    src = mode_reg ? qe : (|terms);
    epo = pol_inv ? ~src : src;
    epi = oe_term ? epo : ext_lvl;
    efb = mode_reg ? ~qe : epi;
    chk(req, pad_o, epo, "pad_o");
    chk(req, pad_oe, oe_term, "pad_oe");
    chk(req, fb, efb, "fb");
    @(posedge clk);
    if (!rst_n || ar_term) qm = 1'b0;
    else if (preload_en)   qm = preload_val;
    else if (sp_term)      qm = 1'b1;
    else                   qm = |terms;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: power-up reset, registered inverted, pin must read 1
    terms = '1;
    run("R8"); run("R8");
    rst_n = 1'b1;
    terms = '0;
    run("R8");

    // R1: combinatorial, true polarity, walking terms
    mode_reg = 1'b0; pol_inv = 1'b0;
    for (int i = 0; i < NT; i++) begin terms = '0; terms[i] = 1'b1; run("R1"); end
    terms = '0; run("R1");
    // R3: combinatorial inverted
    pol_inv = 1'b1;
    terms = 10'h200; run("R3"); terms = '0; run("R3");

    // R2: registered true polarity
    mode_reg = 1'b1; pol_inv = 1'b0;
    terms = 10'h001; run("R2"); terms = '0; run("R2"); terms = 10'h300; run("R2"); run("R2");
    // R3: registered inverted
    pol_inv = 1'b1;
    terms = '0; run("R3"); terms = 10'h010; run("R3"); run("R3");

    // R4 / R10: driver off, combinatorial feedback takes external level
    mode_reg = 1'b0; pol_inv = 1'b0; oe_term = 1'b0;
    terms = '1; ext_lvl = 1'b0; run("R4"); run("R10");
    terms = '0; ext_lvl = 1'b1; run("R4"); run("R10");
    oe_term = 1'b1; run("R10");
    // R10: registered feedback
    mode_reg = 1'b1; terms = '1; run("R10"); terms = '0; run("R10");

    // R5: clear mid-cycle, both polarities
    terms = '1; run("R5"); run("R5");
    ar_term = 1'b1; run("R5");
    ar_term = 1'b0; run("R5"); run("R5");
    pol_inv = 1'b1; ar_term = 1'b1; run("R5");
    ar_term = 1'b0; terms = '0;

    // R6: set with zero terms
    run("R6"); sp_term = 1'b1; run("R6"); sp_term = 1'b0; run("R6"); run("R6");

    // R7: clear beats set and preload
    ar_term = 1'b1; sp_term = 1'b1; run("R7"); run("R7");
    sp_term = 1'b0; preload_en = 1'b1; preload_val = 1'b1; run("R7");
    ar_term = 1'b0; preload_en = 1'b0; run("R7");

    // R9: preload 1, then preload 0 over set
    preload_en = 1'b1; preload_val = 1'b1; run("R9");
    preload_en = 1'b0; terms = '1; run("R9");
    preload_en = 1'b1; preload_val = 1'b0; sp_term = 1'b1; run("R9");
    preload_en = 1'b0; sp_term = 1'b0; terms = '0; run("R9"); run("R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule